// File: doc/BRIEF.md
# Sequenced Toggle Pulse Generator

This block produces a waveform on one output pin from a short table of interval lengths. A prescaler divides the core clock into a fixed tick, and an up-counter compares its tick count against the active interval. Each compare event inverts the pin and loads the next interval from the table. A run begins with a delay at the idle (high) level. The first toggle at the end of that delay always drives the pin low, and every table entry after it adds one more interval.

Software fills the table through a write port while the block is idle. It then starts a run, giving the delay length and the number of entries at the same time. A new start that arrives during a run drops the old run at once and begins again from the idle level, whatever the pin was doing. A separate force command drives the pin back to idle without stopping the run, so the next compare event toggles it low again.

Top module: `seqToggleGen`

## Requirements
- R1: After reset `pulseOut` is 1 and `done` is 0. While no run is active, `pulseOut` stays 1.
- R2: A start sampled at clock edge E latches `delayTicks`. `pulseOut` stays 1 until edge E + D·TICK_DIV, where D is `delayTicks` (0 counts as 1). At that edge `pulseOut` goes to 0.
- R3: Entry k of the table (addresses 0, 1, 2, …) sets the time between one toggle and the next. That time is V·TICK_DIV clock cycles, where V is the entry value. At each such compare event `pulseOut` inverts.
- R4: At the compare event that ends the last entry, `pulseOut` returns to 1 and `done` is 1 for exactly one cycle. An `entryCount` of 0 ends the run at the end of the delay, with no toggle. Any value above DEPTH is treated as DEPTH.
- R5: An interval value of 0 is counted as one tick, so the counter never stalls.
- R6: A start during a run forces `pulseOut` to 1 at the edge where the start is sampled. No later events of the old run occur. The new run times from that edge, and its first toggle goes to 0 whatever the parity of the old run's toggles.
- R7: `forceIdle` sampled at an edge sets `pulseOut` to 1 at that edge. An active run keeps its timing, and its next compare event toggles the pin to 0. In idle, `forceIdle` leaves `pulseOut` at 1.
- R8: When `wrEn` is high and no run is active, `wrData` is stored at table address `wrAddr`. A write that arrives during a run is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle command that starts or restarts a run |
| delayTicks | input | CNT_W | Length of the initial delay in ticks, latched on start |
| entryCount | input | ADDR_W+1 | Number of table entries to play, latched on start |
| forceIdle | input | 1 | Drives the pin to idle and re-arms toggling |
| wrEn | input | 1 | Table write strobe, honoured only when idle |
| wrAddr | input | ADDR_W | Table write address |
| wrData | input | CNT_W | Interval value to store, in ticks |
| pulseOut | output | 1 | Waveform output, idle high |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The runs cover several patterns: an odd entry count, a zero delay with a zero entry inside the table, a zero entry count, and an oversize count that must be clamped to the full table. Together these separate correct tick scaling from off-by-one counting and from a stalled counter. One restart is issued while the pin is low after an odd number of toggles, which shows whether the toggle phase is reset or carried over. A force pulse during a low phase shows that the pin is reset while the run's timing goes on. Forces in idle and writes during a run must leave the pin and later intervals unchanged.

// File: rtl/seqtg_pkg.sv
package seqtg_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DELAY = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic restart;   // reload delay, clear counters, pin to idle
    logic advance;   // toggle pin, load next table entry
    logic finish;    // pin to idle, end of run
    logic forceIdle; // pin to idle, timing untouched
    logic run;       // counting enabled
  } seqStrb_t;

endpackage

// File: rtl/seqtg_datapath.sv
module seqtg_datapath
  import seqtg_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int DEPTH    = 16,
  parameter int TICK_DIV = 125,
  localparam int ADDR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrb_t          strb,
  input  logic [CNT_W-1:0]  delayTicks,
  input  logic [ADDR_W-1:0] rdIdx,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output logic              cmpEvt,
  output logic              pulseOut
);

  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [CNT_W-1:0] tbl [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             tick;

  function automatic logic [CNT_W-1:0] atLeastOne(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  // Interval table, frozen during a run
  always_ff @(posedge clk) begin
    if (wrEn && !strb.run) tbl[wrAddr] <= wrData;
  end

  // Tick prescaler: variant chosen by TICK_DIV
  generate
    if (TICK_DIV > 1) begin : g_pre
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk) begin
        if (!rstN || strb.restart) preCnt <= '0;
        else if (strb.run)
          preCnt <= (preCnt == PRE_W'(TICK_DIV - 1)) ? '0 : preCnt + 1'b1;
      end
      assign tick = strb.run && (preCnt == PRE_W'(TICK_DIV - 1));
    end else begin : g_nopre
      assign tick = strb.run;
    end
  endgenerate

  assign cmpEvt = tick && (cnt == limit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      limit <= CNT_W'(1);
    end else if (strb.restart) begin
      cnt   <= '0;
      limit <= atLeastOne(delayTicks);
    end else if (strb.advance) begin
      cnt   <= '0;
      limit <= atLeastOne(tbl[rdIdx]);
    end else if (cmpEvt) begin
      cnt   <= '0;
    end else if (tick) begin
      cnt   <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) pulseOut <= 1'b1;
    else if (strb.restart || strb.finish || strb.forceIdle) pulseOut <= 1'b1;
    else if (strb.advance) pulseOut <= ~pulseOut;
  end

  AST_CNT_IN_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    strb.run |-> (cnt < limit && limit != '0)); // R5

  AST_TABLE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && wrEn) |=> tbl[$past(wrAddr)] == $past(tbl[wrAddr])); // R8

endmodule

// File: rtl/seqtg_ctrl.sv
module seqtg_ctrl
  import seqtg_pkg::*;
#(
  parameter int DEPTH   = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W:0]   entryCount,
  input  logic              forceIdle,
  input  logic              cmpEvt,
  output seqStrb_t          strb,
  output logic [ADDR_W-1:0] rdIdx,
  output phase_t            phase,
  output logic              done
);

  logic [ADDR_W:0] idx;
  logic [ADDR_W:0] len;
  logic [ADDR_W:0] lenClamped;

  assign lenClamped = (entryCount > (ADDR_W+1)'(DEPTH)) ? (ADDR_W+1)'(DEPTH) : entryCount;
  assign rdIdx      = idx[ADDR_W-1:0];

  always_comb begin
    strb           = '0;
    strb.forceIdle = forceIdle;
    strb.run       = (phase != PH_IDLE);
    if (start) begin
      strb.restart = 1'b1;
    end else if (phase != PH_IDLE && cmpEvt) begin
      if (idx == len) strb.finish  = 1'b1;
      else            strb.advance = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      idx   <= '0;
      len   <= '0;
      done  <= 1'b0;
    end else begin
      done <= strb.finish;
      if (strb.restart) begin
        phase <= PH_DELAY;
        idx   <= '0;   // stale position of an aborted run is dropped
        len   <= lenClamped;
      end else if (strb.finish) begin
        phase <= PH_IDLE;
      end else if (strb.advance) begin
        phase <= PH_RUN;
        idx   <= idx + 1'b1;
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R4

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE) |-> (idx <= len && len <= (ADDR_W+1)'(DEPTH))); // R4

endmodule

// File: rtl/seqToggleGen.sv
module seqToggleGen
  import seqtg_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int DEPTH    = 16,
  parameter int TICK_DIV = 125,
  localparam int ADDR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  delayTicks,
  input  logic [ADDR_W:0]   entryCount,
  input  logic              forceIdle,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output logic              pulseOut,
  output logic              done
);

  seqStrb_t          strb;
  phase_t            phase;
  logic              cmpEvt;
  logic [ADDR_W-1:0] rdIdx;

  seqtg_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .entryCount(entryCount),
    .forceIdle(forceIdle), .cmpEvt(cmpEvt), .strb(strb), .rdIdx(rdIdx),
    .phase(phase), .done(done)
  );

  seqtg_datapath #(.CNT_W(CNT_W), .DEPTH(DEPTH), .TICK_DIV(TICK_DIV)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .delayTicks(delayTicks),
    .rdIdx(rdIdx), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cmpEvt(cmpEvt), .pulseOut(pulseOut)
  );

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE) |-> pulseOut); // R1

  AST_FIRST_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DELAY && strb.advance && !forceIdle) |=> !pulseOut); // R2

  AST_RESTART_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (pulseOut && phase == PH_DELAY)); // R6

  AST_FORCE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    forceIdle |=> pulseOut); // R7

endmodule

// File: tb/tb_seqToggleGen.sv
module tb_seqToggleGen;

  localparam int CNT_W  = 16;
  localparam int DEPTH  = 16;
  localparam int DIV    = 2;
  localparam int ADDR_W = $clog2(DEPTH);

  typedef struct {
    int    cyc;
    bit    lvl;
    bit    dn;
    string req;
  } evItem_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [CNT_W-1:0]  delayTicks = '0;
  logic [ADDR_W:0]   entryCount = '0;
  logic              forceIdle = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [CNT_W-1:0]  wrData = '0;
  logic              pulseOut;
  logic              done;

  int      cyc = 0;
  int      checks = 0;
  int      failures = 0;
  bit      finished = 0;
  bit      prevOut = 1'b1;
  int      tab [DEPTH];
  evItem_t q [$];

  always #4 clk = ~clk;   // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  seqToggleGen #(.CNT_W(CNT_W), .DEPTH(DEPTH), .TICK_DIV(DIV)) dut (
    .clk(clk), .rstN(rstN), .start(start), .delayTicks(delayTicks),
    .entryCount(entryCount), .forceIdle(forceIdle), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .pulseOut(pulseOut), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ticksOf(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // Monitor: pops one expected item per output change or done pulse
  always @(negedge clk) begin
    if (rstN) begin
      if (pulseOut != prevOut || done) begin
        if (q.size() == 0) begin
          check(1'b0, "R3", "unexpected output event at cycle", cyc, -1);
        end else begin
          evItem_t it;
          it = q.pop_front();
          check(cyc == it.cyc, it.req, "event cycle", cyc, it.cyc);
          check(pulseOut == it.lvl, it.req, "pulseOut level", int'(pulseOut), int'(it.lvl));
          check(done == it.dn, it.req, "done flag", int'(done), int'(it.dn));
        end
      end
      prevOut = pulseOut;
    end
  end

  task automatic insertItem(input evItem_t it);
    int pos = 0;
    while (pos < q.size() && q[pos].cyc <= it.cyc) pos++;
    q.insert(pos, it);
  endtask

  task automatic wrTab(input int a, input int v);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = ADDR_W'(a); wrData = CNT_W'(v);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Driver: issues a start and pushes the expected events of the run
  task automatic startSeq(input int d, input int n);
    int c;
    int t;
    int nn;
    bit lvl;
    @(negedge clk);
    c = cyc + 1;
    for (int i = q.size() - 1; i >= 0; i--) if (q[i].cyc >= c) q.delete(i);
    if (pulseOut == 1'b0) insertItem('{c, 1'b1, 1'b0, "R6"});
    start = 1'b1; delayTicks = CNT_W'(d); entryCount = (ADDR_W+1)'(n);
    nn = (n > DEPTH) ? DEPTH : n;
    t = c + ticksOf(d) * DIV;
    if (nn == 0) begin
      insertItem('{t, 1'b1, 1'b1, "R4"});
    end else begin
      insertItem('{t, 1'b0, 1'b0, "R2"});
      lvl = 1'b0;
      for (int k = 0; k < nn; k++) begin
        t += ticksOf(tab[k]) * DIV;
        if (k == nn - 1) insertItem('{t, 1'b1, 1'b1, "R4"});
        else begin
          lvl = ~lvl;
          insertItem('{t, lvl, 1'b0, (tab[k] == 0) ? "R5" : "R3"});
        end
      end
    end
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic forcePulse();
    int c;
    @(negedge clk);
    c = cyc + 1;
    if (pulseOut == 1'b0) begin
      foreach (q[i]) if (!q[i].dn && q[i].cyc > c) q[i].lvl = ~q[i].lvl;
      insertItem('{c, 1'b1, 1'b0, "R7"});
    end
    forceIdle = 1'b1;
    @(negedge clk);
    forceIdle = 1'b0;
  endtask

  task automatic waitLow();
    do @(negedge clk); while (pulseOut != 1'b0);
  endtask

  task automatic waitEnd();
    while (q.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int init [DEPTH] = '{3, 5, 2, 7, 0, 4, 1, 2, 1, 3, 2, 1, 2, 1, 1, 2};
    repeat (4) @(negedge clk);
    check(pulseOut == 1'b1, "R1", "pulseOut after reset", int'(pulseOut), 1);
    check(done == 1'b0, "R1", "done after reset", int'(done), 0);
    rstN = 1'b1;

    // R8: idle writes fill the table
    for (int i = 0; i < DEPTH; i++) begin
      tab[i] = init[i];
      wrTab(i, init[i]);
    end

    startSeq(4, 3); waitEnd();        // R2 R3 R4 basic run
    startSeq(0, 6); waitEnd();        // R2 zero delay, R5 zero entry
    startSeq(3, 0); waitEnd();        // R4 empty run
    startSeq(2, 20); waitEnd();       // R4 clamp to DEPTH

    // R8: write during a run is ignored (entry 2 still 2 ticks)
    startSeq(2, 3);
    wrTab(2, 40);
    waitEnd();
    startSeq(1, 3); waitEnd();        // R8 later run still uses old entry

    // R6: restart while low after an odd toggle count
    startSeq(4, 4);
    waitLow();
    startSeq(3, 2);
    waitEnd();

    // R7: force during low phase, run continues with flipped phase
    startSeq(2, 4);
    waitLow();
    forcePulse();
    waitEnd();

    // R7: force in idle has no effect
    forcePulse();
    repeat (3) @(negedge clk);
    check(pulseOut == 1'b1, "R7", "pulseOut after idle force", int'(pulseOut), 1);
    check(q.size() == 0, "R4", "pending expected events", q.size(), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R1: watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule